// File: doc/BRIEF.md
# Load-Use Stall Detector

This block sits beside the decode stage of a five-stage in-order pipeline. It catches the one read-after-write case that operand bypassing cannot cover. The case arises when the instruction being decoded reads a register, and the load now in the execute stage has not yet brought that register's value back from memory. When this happens, the detector freezes the program counter and the fetch/decode register for one cycle. In the same cycle it replaces the control word entering the execute stage with all zeros, so that a bubble moves down the pipe in place of the dependent instruction.

The match is qualified in three ways: by the memory-read flag of the instruction in execute, by a non-zero destination, and by a per-source flag telling whether the decoding instruction actually reads that operand. The block is purely combinational and keeps no state. One cycle later the load has moved on to the memory stage, and the bubble's cleared read flag removes the stall without further help.

Top module: `load_use_stall`

## Requirements
- R1: When `exMemRead` is 1, `exDestId` is non-zero, and a used source (`idRsUsed` with `idRsId`, or `idRtUsed` with `idRtId`) equals `exDestId`, then `pcWrite` = 0, `ifidWrite` = 0 and `ctrlZero` = 1 in the same cycle.
- R2: When `exMemRead` is 0, no stall occurs: `pcWrite` = 1, `ifidWrite` = 1, `ctrlZero` = 0, whatever the register ids are.
- R3: A load whose destination is register 0 (`exDestId` = 0) never causes a stall, even when both sources are 0 and used.
- R4: A source whose use flag is 0 is ignored: its id matching `exDestId` causes no stall unless the other, used source matches.
- R5: `exCtrl` equals `idCtrl` when there is no stall, and is all zeros when there is a stall.
- R6: `pcWrite` and `ifidWrite` are always equal, and `ctrlZero` is always their inverse.
- R7: The outputs depend only on the present inputs. Applying the same input vector after a different history gives the same outputs. A stall lasts exactly one cycle when the next cycle presents the bubble (`exMemRead` = 0) in execute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| idRsId | input | 5 | First source register id of the instruction in decode |
| idRtId | input | 5 | Second source register id of the instruction in decode |
| idRsUsed | input | 1 | Decoding instruction reads its first source |
| idRtUsed | input | 1 | Decoding instruction reads its second source |
| exDestId | input | 5 | Destination register id of the instruction in execute |
| exMemRead | input | 1 | Instruction in execute is a load |
| idCtrl | input | 8 | Control word produced by decode for the execute stage |
| pcWrite | output | 1 | Program counter update enable |
| ifidWrite | output | 1 | Fetch/decode pipeline register update enable |
| ctrlZero | output | 1 | Bubble select: 1 zeroes the control word |
| exCtrl | output | 8 | Control word passed into the execute-stage register |

## Verification
Two functions can act in the same cycle. The two source comparators can both hit the load's destination at once, and a hit on an unused source can coincide with a hit on a used one. The bench provokes these with directed vectors where both ids equal the destination, each with a different use flag. It then drives random vectors drawn from a small register pool, so that double and masked matches recur often. Each result is judged against a bench function: the hold is taken as the OR of the qualified hits, and only a qualified hit on a used source may stall, while the control word must be zero exactly when the hold is asserted.

// File: rtl/load_use_stall_pkg.sv
package load_use_stall_pkg;

  typedef struct packed {
    logic pcWrite;
    logic ifidWrite;
    logic ctrlZero;
  } stall_strobes_t;

endpackage

// File: rtl/lus_datapath.sv
module lus_datapath
  import load_use_stall_pkg::*;
#(
  parameter int AW      = 5,
  parameter int NUM_SRC = 2,
  parameter int CTRL_W  = 8
) (
  input  logic [NUM_SRC*AW-1:0] srcIds,
  input  logic [NUM_SRC-1:0]    srcUsed,
  input  logic [AW-1:0]         loadDest,
  input  logic                  loadPending,
  input  logic [CTRL_W-1:0]     ctrlIn,
  input  stall_strobes_t        strobes,
  output logic                  hazard,
  output logic [CTRL_W-1:0]     ctrlOut
);
  localparam logic [AW-1:0]     ZERO_REG  = '0;
  localparam logic [CTRL_W-1:0] BUBBLE_CW = '0;

  logic [NUM_SRC-1:0] srcHit;
  logic               destLive;

  // a load only matters when it targets a real register
  assign destLive = loadPending && (loadDest != ZERO_REG);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
    assign srcHit[i] = srcUsed[i] && (srcIds[i*AW +: AW] == loadDest);
  end

  assign hazard  = destLive && (|srcHit);
  assign ctrlOut = strobes.ctrlZero ? BUBBLE_CW : ctrlIn;

  // control must answer a detected hazard with a full hold
  always_comb begin
    if (hazard) begin
      p_hold_on_hazard_r1: assert (strobes.ctrlZero && !strobes.pcWrite && !strobes.ifidWrite)
        else $error("hazard without hold");
    end
    if (!hazard) begin
      p_free_run_r2: assert (!strobes.ctrlZero && strobes.pcWrite && strobes.ifidWrite)
        else $error("hold without hazard");
    end
  end
endmodule

// File: rtl/lus_control.sv
module lus_control
  import load_use_stall_pkg::*;
(
  input  logic           hazard,
  output stall_strobes_t strobes
);
  always_comb begin
    strobes.pcWrite   = 1'b1;
    strobes.ifidWrite = 1'b1;
    strobes.ctrlZero  = 1'b0;
    if (hazard) begin
      strobes.pcWrite   = 1'b0;
      strobes.ifidWrite = 1'b0;
      strobes.ctrlZero  = 1'b1;
    end
  end
endmodule

// File: rtl/load_use_stall.sv
module load_use_stall
  import load_use_stall_pkg::*;
#(
  parameter int AW     = 5,
  parameter int CTRL_W = 8
) (
  input  logic [AW-1:0]     idRsId,
  input  logic [AW-1:0]     idRtId,
  input  logic              idRsUsed,
  input  logic              idRtUsed,
  input  logic [AW-1:0]     exDestId,
  input  logic              exMemRead,
  input  logic [CTRL_W-1:0] idCtrl,
  output logic              pcWrite,
  output logic              ifidWrite,
  output logic              ctrlZero,
  output logic [CTRL_W-1:0] exCtrl
);
  localparam int NUM_SRC = 2;

  stall_strobes_t strobes;
  logic           hazard;

  lus_datapath #(.AW(AW), .NUM_SRC(NUM_SRC), .CTRL_W(CTRL_W)) u_dp (
    .srcIds      ({idRtId, idRsId}),
    .srcUsed     ({idRtUsed, idRsUsed}),
    .loadDest    (exDestId),
    .loadPending (exMemRead),
    .ctrlIn      (idCtrl),
    .strobes     (strobes),
    .hazard      (hazard),
    .ctrlOut     (exCtrl)
  );

  lus_control u_ctl (
    .hazard  (hazard),
    .strobes (strobes)
  );

  assign pcWrite   = strobes.pcWrite;
  assign ifidWrite = strobes.ifidWrite;
  assign ctrlZero  = strobes.ctrlZero;

  always_comb begin
    if (!exMemRead) begin
      p_no_load_r2: assert (pcWrite && ifidWrite) else $error("stall without load");
    end
    if (exDestId == '0) begin
      p_zero_dest_r3: assert (pcWrite) else $error("stall on register 0");
    end
    if (!idRsUsed && !idRtUsed) begin
      p_unused_src_r4: assert (pcWrite) else $error("stall on unused sources");
    end
    if (ctrlZero) begin
      p_bubble_r5: assert (exCtrl == '0) else $error("bubble not zero");
    end else begin
      p_pass_r5: assert (exCtrl == idCtrl) else $error("control word altered");
    end
    p_enables_r6: assert (pcWrite == ifidWrite) else $error("enables differ");
  end
endmodule

// File: tb/sim_load_use_stall.sv
module sim_load_use_stall;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] idRsId = '0, idRtId = '0, exDestId = '0;
  logic       idRsUsed = 1'b0, idRtUsed = 1'b0, exMemRead = 1'b0;
  logic [7:0] idCtrl = '0;
  logic       pcWrite, ifidWrite, ctrlZero;
  logic [7:0] exCtrl;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  load_use_stall u0 (
    .idRsId(idRsId), .idRtId(idRtId), .idRsUsed(idRsUsed), .idRtUsed(idRtUsed),
    .exDestId(exDestId), .exMemRead(exMemRead), .idCtrl(idCtrl),
    .pcWrite(pcWrite), .ifidWrite(ifidWrite), .ctrlZero(ctrlZero), .exCtrl(exCtrl)
  );

  function automatic bit expStall(input logic [4:0] rs, input logic [4:0] rt,
                                  input logic ur, input logic ut,
                                  input logic [4:0] d, input logic mr);
    return mr && (d != 5'd0) && ((ur && rs == d) || (ut && rt == d));
  endfunction

  task automatic apply(input logic [4:0] rs, input logic [4:0] rt, input logic ur,
                       input logic ut, input logic [4:0] d, input logic mr, input logic [7:0] cw);
    @(negedge clk);
    idRsId = rs; idRtId = rt; idRsUsed = ur; idRtUsed = ut;
    exDestId = d; exMemRead = mr; idCtrl = cw;
    #2;
  endtask

  task automatic check(input string tag);
    bit st;
    logic [7:0] ecw;
    st  = expStall(idRsId, idRtId, idRsUsed, idRtUsed, exDestId, exMemRead);
    ecw = st ? 8'h00 : idCtrl;
    checks++;
    if (pcWrite !== !st || ifidWrite !== !st || ctrlZero !== st) begin
      errors++;
      $display("FAIL %s: pc=%0b ifid=%0b zero=%0b expected pc=%0b ifid=%0b zero=%0b",
               tag, pcWrite, ifidWrite, ctrlZero, !st, !st, st);
    end
    checks++;
    if (exCtrl !== ecw) begin
      errors++;
      $display("FAIL R5 (%s): exCtrl=%h expected %h", tag, exCtrl, ecw);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] histCw;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #2;
    check("R2 reset state");
    rst = 1'b0;

    apply(5'd3, 5'd9, 1, 1, 5'd3, 1, 8'hA5); check("R1 rs match");
    apply(5'd4, 5'd7, 1, 1, 5'd7, 1, 8'h3C); check("R1 rt match");
    apply(5'd6, 5'd6, 1, 1, 5'd6, 1, 8'hFF); check("R1 both match");
    apply(5'd6, 5'd6, 1, 1, 5'd6, 0, 8'h81); check("R2 no load");
    apply(5'd0, 5'd0, 1, 1, 5'd0, 1, 8'h42); check("R3 dest zero");
    apply(5'd8, 5'd2, 1, 0, 5'd2, 1, 8'h17); check("R4 rt unused");
    apply(5'd2, 5'd8, 0, 1, 5'd2, 1, 8'h29); check("R4 rs unused");
    apply(5'd5, 5'd5, 0, 1, 5'd5, 1, 8'h5A); check("R4 masked plus used");
    apply(5'd1, 5'd2, 1, 1, 5'd31, 1, 8'hC3); check("R6 no match");

    // R7: load-use pair, then bubble in execute -> exactly one stall cycle
    apply(5'd10, 5'd11, 1, 1, 5'd11, 1, 8'h66); check("R7 stall cycle");
    apply(5'd10, 5'd11, 1, 1, 5'd11, 0, 8'h66); check("R7 released");
    // R7: same vector after different history
    apply(5'd12, 5'd13, 1, 1, 5'd12, 1, 8'h99); check("R7 first");
    apply(5'd1, 5'd1, 0, 0, 5'd0, 0, 8'h00);   check("R7 other");
    apply(5'd12, 5'd13, 1, 1, 5'd12, 1, 8'h99); check("R7 repeat");

    for (int i = 0; i < 3000; i++) begin
      logic [4:0] rs, rt, d;
      rs = 5'($urandom_range(0, 4));
      rt = 5'($urandom_range(0, 4));
      d  = 5'($urandom_range(0, 4));
      histCw = 8'($urandom);
      apply(rs, rt, 1'($urandom), 1'($urandom), d, 1'($urandom), histCw);
      check("R1/R4 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule